// File: doc/BRIEF.md
# Receive PHY Management Register Bridge

This block is a memory-mapped slave that lets a word-oriented host control and monitor a receive PHY. The host address space has two parts. The low part is a window onto the byte-addressed reconfiguration bus of one of several transceiver channels. Above it sits a small bank of control and status registers.

A window access is forwarded only when software has set the forwarding enable and has selected a valid channel. The host offset is divided by four before it reaches the downstream bus. While a forwarded access is in flight, the host is stalled by the selected channel's waitrequest.

The register bank does three things:
- It holds the channel select, the forwarding enable and the receive reset control.
- It reflects status inputs: a clock measurement with its valid flag, calibration done and calibration busy.
- It reflects the live waitrequest level of the selected channel and a fixed configuration bit.

Register accesses never stall. Host transfers follow a zero-latency read convention: read data is valid in the cycle in which `host_waitreq` is low.

Top module: `rxphy_mgmt_bridge`

## Requirements
- R1: A host access at an offset below 0x1000 that is forwarded asserts the read or write strobe of the selected channel only. It drives the downstream address with the host offset shifted right by two (host 0x0400 gives 0x100) and passes the host write data unchanged.
- R2: The channel select field is bits 1:0 of offset 0x1040. It is read/write and resets to 0. Values 0 to 2 pick that channel. Value 3 means no channel: window accesses then raise no strobe, complete with no wait, and read 0.
- R3: The forwarding enable is bit 0 of offset 0x1050. It is read/write and resets to 0. While it is 0, window accesses raise no strobe, complete with no wait, read 0, and drop their writes.
- R4: During a forwarded access, `host_waitreq` equals the selected channel's waitrequest. Waitrequests of the other channels have no effect. The read data returned in the cycle `host_waitreq` is low is that channel's read data.
- R5: The receive reset control is bit 0 of offset 0x1060. It is read/write and resets to 0. `rx_xcvr_reset` equals this bit from the cycle after the write.
- R6: The following status registers are read-only:
  - Offset 0x1000 returns the 32-bit measurement input.
  - Offsets 0x1010, 0x1020 and 0x1030 return, in bit 0, the measurement-valid flag, calibration done and calibration busy respectively.
  - All their other bits read 0.
- R7: Offset 0x1070 returns in bit 0 the current waitrequest level of the selected channel. It returns 0 when no channel is selected.
- R8: Offset 0x1080 reads 0, meaning the default PLL choice.
- R9: Register-bank accesses complete in the same cycle with `host_waitreq` low.
- R10: Writes to read-only registers and to undecoded offsets change no state. Reads of undecoded offsets return 0. Undecoded offsets include those at or above 0x1000 that are not one of the nine listed offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 16 | Host byte offset |
| host_read | input | 1 | Host read request, held while stalled |
| host_write | input | 1 | Host write request, held while stalled |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid when host_waitreq is low |
| host_waitreq | output | 1 | Host stall |
| xcvr_addr | output | 10 | Downstream byte address, shared by all channels |
| xcvr_read | output | 3 | Per-channel downstream read strobe |
| xcvr_write | output | 3 | Per-channel downstream write strobe |
| xcvr_wdata | output | 32 | Downstream write data, shared |
| xcvr_rdata | input | 96 | Per-channel downstream read data, channel n in bits 32n+31:32n |
| xcvr_waitreq | input | 3 | Per-channel downstream waitrequest |
| meas_value | input | 32 | Receive clock measurement |
| meas_valid | input | 1 | Measurement valid flag |
| cal_done | input | 1 | Power-up calibration complete |
| cal_busy | input | 1 | Receive calibration in progress |
| rx_xcvr_reset | output | 1 | Receive analog and digital reset |

## Verification
Two of the block's functions can meet in adjacent or identical cycles.

The first pairing is a channel-select or enable write immediately followed by a window access. The bench issues such a write and then, with no idle cycle, a window access. It judges whether the strobes and the stall already follow the new setting.

The second pairing is the waitrequest status readback and a busy downstream channel. Every cycle, the waitrequest inputs of all channels carry random noise, including during register reads. The bench judges that only the selected channel's level appears in the 0x1070 read and in `host_waitreq`.

// File: rtl/rxphy_mgmt_pkg.sv
package rxphy_mgmt_pkg;

   localparam int NUM_REGS = 9;

   // Slot order sets the offset (base + slot * stride).
   typedef enum logic [3:0] {
      SLOT_MEAS    = 4'd0,
      SLOT_MVALID  = 4'd1,
      SLOT_CALDONE = 4'd2,
      SLOT_CALBUSY = 4'd3,
      SLOT_CHSEL   = 4'd4,
      SLOT_FWDEN   = 4'd5,
      SLOT_RXRST   = 4'd6,
      SLOT_WAITST  = 4'd7,
      SLOT_CONFIG  = 4'd8
   } reg_slot_e;

   typedef enum logic [1:0] {
      AREA_NONE   = 2'd0,
      AREA_WINDOW = 2'd1,
      AREA_REGS   = 2'd2
   } area_e;

   typedef struct packed {
      area_e     area;
      reg_slot_e slot;
   } decode_t;

endpackage

// File: rtl/rxphy_addr_decode.sv
module rxphy_addr_decode
   import rxphy_mgmt_pkg::*;
#(
   parameter int HOST_AW    = 16,
   parameter int WIN_BYTES  = 4096,
   parameter int REG_BASE   = 'h1000,
   parameter int REG_STRIDE = 'h10
) (
   input  logic [HOST_AW-1:0] addr,
   output decode_t            dec
);
   localparam int STRIDE_SH = $clog2(REG_STRIDE);
   localparam logic [HOST_AW-1:0] WIN_END = HOST_AW'(WIN_BYTES);
   localparam logic [HOST_AW-1:0] BASE_V  = HOST_AW'(REG_BASE);
   localparam logic [HOST_AW-1:0] NREG_V  = HOST_AW'(NUM_REGS);

   logic [HOST_AW-1:0] rel;
   logic [HOST_AW-1:0] slot_num;

   always_comb begin
      rel      = addr - BASE_V;
      slot_num = rel >> STRIDE_SH;
      dec.area = AREA_NONE;
      dec.slot = SLOT_MEAS;
      if (addr < WIN_END) begin
         dec.area = AREA_WINDOW;
      end else if (addr >= BASE_V && rel[STRIDE_SH-1:0] == '0 && slot_num < NREG_V) begin
         dec.area = AREA_REGS;
         dec.slot = reg_slot_e'(slot_num[3:0]);
      end
   end
endmodule

// File: rtl/rxphy_ctrl_regs.sv
module rxphy_ctrl_regs
   import rxphy_mgmt_pkg::*;
#(
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  reg_slot_e        slot,
   input  logic [SEL_W-1:0] wbits,
   output logic [SEL_W-1:0] chan_sel,
   output logic             fwd_en,
   output logic             rx_rst
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chan_sel <= '0;
         fwd_en   <= 1'b0;
         rx_rst   <= 1'b0;
      end else if (wr_en) begin
         unique case (slot)
            SLOT_CHSEL: chan_sel <= wbits;
            SLOT_FWDEN: fwd_en   <= wbits[0];
            SLOT_RXRST: rx_rst   <= wbits[0];
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/rxphy_win_fwd.sv
module rxphy_win_fwd #(
   parameter int NUM_CH = 3,
   parameter int DATA_W = 32,
   parameter int SEL_W  = 2,
   parameter int DS_AW  = 10
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     win_rd,
   input  logic                     win_wr,
   input  logic                     fwd_en,
   input  logic [SEL_W-1:0]         chan_sel,
   input  logic [DS_AW-1:0]         word_off,
   input  logic [DATA_W-1:0]        wdata,
   output logic [DS_AW-1:0]         xcvr_addr,
   output logic [NUM_CH-1:0]        xcvr_read,
   output logic [NUM_CH-1:0]        xcvr_write,
   output logic [DATA_W-1:0]        xcvr_wdata,
   input  logic [NUM_CH*DATA_W-1:0] xcvr_rdata,
   input  logic [NUM_CH-1:0]        xcvr_waitreq,
   output logic                     sel_wait,
   output logic                     fwd_wait,
   output logic [DATA_W-1:0]        fwd_rdata
);
   logic [NUM_CH-1:0] hit;
   logic [DATA_W-1:0] masked [NUM_CH];

   assign xcvr_addr  = word_off;
   assign xcvr_wdata = wdata;

   genvar g;
   generate
      for (g = 0; g < NUM_CH; g++) begin : g_ch
         assign hit[g]        = (chan_sel == SEL_W'(g));
         assign xcvr_read[g]  = fwd_en & hit[g] & win_rd;
         assign xcvr_write[g] = fwd_en & hit[g] & win_wr;
         assign masked[g]     = (fwd_en & hit[g] & win_rd) ? xcvr_rdata[g*DATA_W +: DATA_W] : '0;
      end
   endgenerate

   always_comb begin
      fwd_rdata = '0;
      for (int k = 0; k < NUM_CH; k++) fwd_rdata = fwd_rdata | masked[k];
   end

   assign sel_wait = |(hit & xcvr_waitreq);
   assign fwd_wait = fwd_en & (win_rd | win_wr) & sel_wait;

   assert_strobe_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(xcvr_read | xcvr_write));
   assert_gate_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !fwd_en |-> (xcvr_read == '0 && xcvr_write == '0 && !fwd_wait));
   assert_no_channel_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_sel >= SEL_W'(NUM_CH)) |-> (xcvr_read == '0 && xcvr_write == '0 && fwd_rdata == '0));
endmodule

// File: rtl/rxphy_mgmt_bridge.sv
module rxphy_mgmt_bridge
   import rxphy_mgmt_pkg::*;
#(
   parameter int          HOST_AW    = 16,
   parameter int          DATA_W     = 32,
   parameter int          NUM_CH     = 3,
   parameter int          WIN_BYTES  = 4096,
   parameter int          REG_BASE   = 'h1000,
   parameter int          REG_STRIDE = 'h10,
   parameter logic        ALT_PLL    = 1'b0,
   localparam int         SEL_W      = $clog2(NUM_CH + 1),
   localparam int         WIN_AW     = $clog2(WIN_BYTES),
   localparam int         DS_AW      = WIN_AW - 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [HOST_AW-1:0]       host_addr,
   input  logic                     host_read,
   input  logic                     host_write,
   input  logic [DATA_W-1:0]        host_wdata,
   output logic [DATA_W-1:0]        host_rdata,
   output logic                     host_waitreq,
   output logic [DS_AW-1:0]         xcvr_addr,
   output logic [NUM_CH-1:0]        xcvr_read,
   output logic [NUM_CH-1:0]        xcvr_write,
   output logic [DATA_W-1:0]        xcvr_wdata,
   input  logic [NUM_CH*DATA_W-1:0] xcvr_rdata,
   input  logic [NUM_CH-1:0]        xcvr_waitreq,
   input  logic [DATA_W-1:0]        meas_value,
   input  logic                     meas_valid,
   input  logic                     cal_done,
   input  logic                     cal_busy,
   output logic                     rx_xcvr_reset
);
   generate
      if (NUM_CH < 1) begin : g_chk_ch
         $error("NUM_CH must be at least 1");
      end
      if (REG_BASE < WIN_BYTES) begin : g_chk_base
         $error("register bank overlaps the window");
      end
      if ((REG_STRIDE & (REG_STRIDE - 1)) != 0 || REG_STRIDE < 4) begin : g_chk_stride
         $error("REG_STRIDE must be a power of two of at least 4");
      end
      if ((WIN_BYTES & (WIN_BYTES - 1)) != 0 || WIN_BYTES < 8) begin : g_chk_win
         $error("WIN_BYTES must be a power of two");
      end
      if (DATA_W < SEL_W) begin : g_chk_dw
         $error("DATA_W too narrow");
      end
   endgenerate

   decode_t           dec;
   logic [SEL_W-1:0]  chan_sel;
   logic              fwd_en;
   logic              rx_rst;
   logic              sel_wait;
   logic              fwd_wait;
   logic [DATA_W-1:0] fwd_rdata;
   logic [DATA_W-1:0] reg_rdata;
   logic              in_win;
   logic              in_regs;

   rxphy_addr_decode #(
      .HOST_AW(HOST_AW), .WIN_BYTES(WIN_BYTES),
      .REG_BASE(REG_BASE), .REG_STRIDE(REG_STRIDE)
   ) u_dec (
      .addr(host_addr), .dec(dec)
   );

   assign in_win  = (dec.area == AREA_WINDOW);
   assign in_regs = (dec.area == AREA_REGS);

   rxphy_ctrl_regs #(.SEL_W(SEL_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(host_write & in_regs), .slot(dec.slot),
      .wbits(host_wdata[SEL_W-1:0]),
      .chan_sel(chan_sel), .fwd_en(fwd_en), .rx_rst(rx_rst)
   );

   rxphy_win_fwd #(
      .NUM_CH(NUM_CH), .DATA_W(DATA_W), .SEL_W(SEL_W), .DS_AW(DS_AW)
   ) u_fwd (
      .clk(clk), .rst_n(rst_n),
      .win_rd(host_read & in_win), .win_wr(host_write & in_win),
      .fwd_en(fwd_en), .chan_sel(chan_sel),
      .word_off(host_addr[WIN_AW-1:2]), .wdata(host_wdata),
      .xcvr_addr(xcvr_addr), .xcvr_read(xcvr_read), .xcvr_write(xcvr_write),
      .xcvr_wdata(xcvr_wdata), .xcvr_rdata(xcvr_rdata), .xcvr_waitreq(xcvr_waitreq),
      .sel_wait(sel_wait), .fwd_wait(fwd_wait), .fwd_rdata(fwd_rdata)
   );

   always_comb begin
      reg_rdata = '0;
      unique case (dec.slot)
         SLOT_MEAS:    reg_rdata    = meas_value;
         SLOT_MVALID:  reg_rdata[0] = meas_valid;
         SLOT_CALDONE: reg_rdata[0] = cal_done;
         SLOT_CALBUSY: reg_rdata[0] = cal_busy;
         SLOT_CHSEL:   reg_rdata[SEL_W-1:0] = chan_sel;
         SLOT_FWDEN:   reg_rdata[0] = fwd_en;
         SLOT_RXRST:   reg_rdata[0] = rx_rst;
         SLOT_WAITST:  reg_rdata[0] = sel_wait;
         SLOT_CONFIG:  reg_rdata[0] = ALT_PLL;
         default:      reg_rdata    = '0;
      endcase
   end

   always_comb begin
      host_rdata = '0;
      if (in_win)       host_rdata = fwd_rdata;
      else if (in_regs) host_rdata = reg_rdata;
   end

   assign host_waitreq  = in_win & fwd_wait;
   assign rx_xcvr_reset = rx_rst;

   assert_reg_nowait_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((host_read | host_write) && !in_win) |-> !host_waitreq);
   assert_rst_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (host_write && in_regs && dec.slot == SLOT_RXRST) |=> (rx_xcvr_reset == $past(host_wdata[0])));
   assert_ignore_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (host_write && dec.area == AREA_NONE) |=> $stable(rx_xcvr_reset));
   assert_undecoded_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (host_read && dec.area == AREA_NONE) |-> (host_rdata == '0));
endmodule

// File: tb/rxphy_mgmt_bridge_test.sv
`timescale 1ns/1ps
module rxphy_mgmt_bridge_test;
   localparam int NCH = 3;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic              rst_n;
   logic [15:0]       host_addr;
   logic              host_read, host_write;
   logic [31:0]       host_wdata, host_rdata;
   logic              host_waitreq;
   logic [9:0]        xcvr_addr;
   logic [NCH-1:0]    xcvr_read, xcvr_write;
   logic [31:0]       xcvr_wdata;
   logic [NCH*32-1:0] xcvr_rdata;
   logic [NCH-1:0]    xcvr_waitreq;
   logic [31:0]       meas_value;
   logic              meas_valid, cal_done, cal_busy;
   logic              rx_xcvr_reset;

   int n_chk = 0;
   int n_bad = 0;
   logic [1:0] sel_m = 2'd0;
   logic       en_m  = 1'b0;
   logic       rst_m = 1'b0;

   rxphy_mgmt_bridge uut (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_read(host_read),
      .host_write(host_write), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .host_waitreq(host_waitreq), .xcvr_addr(xcvr_addr), .xcvr_read(xcvr_read),
      .xcvr_write(xcvr_write), .xcvr_wdata(xcvr_wdata), .xcvr_rdata(xcvr_rdata),
      .xcvr_waitreq(xcvr_waitreq), .meas_value(meas_value), .meas_valid(meas_valid),
      .cal_done(cal_done), .cal_busy(cal_busy), .rx_xcvr_reset(rx_xcvr_reset)
   );

   function automatic logic [31:0] stub_rd(int ch, logic [9:0] a);
      return {8'(ch + 1), 8'hA5, 6'd0, a};
   endfunction

   always_comb begin
      for (int g = 0; g < NCH; g++) xcvr_rdata[g*32 +: 32] = stub_rd(g, xcvr_addr);
   end

   function automatic logic [31:0] exp_reg(logic [15:0] a, logic [NCH-1:0] wq);
      case (a)
         16'h1000: return meas_value;
         16'h1010: return {31'd0, meas_valid};
         16'h1020: return {31'd0, cal_done};
         16'h1030: return {31'd0, cal_busy};
         16'h1040: return {30'd0, sel_m};
         16'h1050: return {31'd0, en_m};
         16'h1060: return {31'd0, rst_m};
         16'h1070: return {31'd0, (sel_m < 2'd3) ? wq[sel_m] : 1'b0};
         default:  return 32'd0;
      endcase
   endfunction

   function automatic string tag_of(logic [15:0] a);
      if (a < 16'h1000) return "R1";
      case (a)
         16'h1000, 16'h1010, 16'h1020, 16'h1030: return "R6";
         16'h1040: return "R2";
         16'h1050: return "R3";
         16'h1060: return "R5";
         16'h1070: return "R7";
         16'h1080: return "R8";
         default:  return "R10";
      endcase
   endfunction

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic acc(input logic is_wr, input logic [15:0] a, input logic [31:0] wd,
                      input int nwait, output logic [31:0] rd);
      logic fwd;
      logic [NCH-1:0] noise;
      logic [31:0] exp_rd;
      string tg;
      fwd = (a < 16'h1000) && en_m && (sel_m < 2'd3);
      tg = tag_of(a);
      if (a < 16'h1000 && !en_m) tg = "R3";
      else if (a < 16'h1000 && sel_m == 2'd3) tg = "R2";
      host_addr = a; host_read = !is_wr; host_write = is_wr; host_wdata = wd;
      meas_value = $urandom; meas_valid = 1'($urandom); cal_done = 1'($urandom); cal_busy = 1'($urandom);
      rd = '0;
      for (int c = 0; c < 64; c++) begin
         noise = NCH'($urandom);
         if (fwd) begin
            noise[sel_m] = (c < nwait);
         end
         xcvr_waitreq = noise;
         #1;
         chk((a < 16'h1000) ? "R4" : "R9", "host_waitreq", {31'd0, host_waitreq},
             {31'd0, fwd && (c < nwait)});
         chk(tg, "read strobes", {29'd0, xcvr_read},
             (fwd && !is_wr) ? (32'd1 << sel_m) : 32'd0);
         chk(tg, "write strobes", {29'd0, xcvr_write},
             (fwd && is_wr) ? (32'd1 << sel_m) : 32'd0);
         if (fwd) begin
            chk("R1", "downstream address", {22'd0, xcvr_addr}, {22'd0, a[11:2]});
            if (is_wr) chk("R1", "downstream wdata", xcvr_wdata, wd);
         end
         if (!host_waitreq) begin
            rd = host_rdata;
            if (!is_wr) begin
               if (a < 16'h1000) exp_rd = fwd ? stub_rd(int'(sel_m), a[11:2]) : 32'd0;
               else exp_rd = exp_reg(a, noise);
               chk(fwd ? "R4" : tg, "read data", rd, exp_rd);
            end
            break;
         end
         @(posedge clk); @(negedge clk);
      end
      @(posedge clk); @(negedge clk);
      host_read = 1'b0; host_write = 1'b0;
      xcvr_waitreq = NCH'($urandom);
      if (is_wr) begin
         case (a)
            16'h1040: sel_m = wd[1:0];
            16'h1050: en_m  = wd[0];
            16'h1060: rst_m = wd[0];
            default: ;
         endcase
      end
      chk("R5", "rx_xcvr_reset", {31'd0, rx_xcvr_reset}, {31'd0, rst_m});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] r;
      logic [15:0] a;
      int pick;
      void'($urandom(32'h5EED1234));
      rst_n = 1'b0; host_addr = '0; host_read = 0; host_write = 0; host_wdata = '0;
      xcvr_waitreq = '0; meas_value = '0; meas_valid = 0; cal_done = 0; cal_busy = 0;
      repeat (3) @(negedge clk);
      chk("R5", "reset output in reset", {31'd0, rx_xcvr_reset}, 32'd0);
      chk("R1", "no strobes in reset", {29'd0, xcvr_read | xcvr_write}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // reset values and status readback
      for (int k = 0; k <= 8; k++) acc(1'b0, 16'(16'h1000 + k * 16), 32'd0, 0, r);
      // forwarding disabled: no strobe, read 0 (R3)
      acc(1'b0, 16'h0400, 32'd0, 3, r);
      acc(1'b1, 16'h0400, 32'h1234_5678, 3, r);
      // enable, translated read on channel 0 with stall (R1 R4)
      acc(1'b1, 16'h1050, 32'd1, 0, r);
      acc(1'b0, 16'h0400, 32'd0, 2, r);
      chk("R1", "host 0x0400 maps to 0x100", r, stub_rd(0, 10'h100));
      // select write immediately followed by a window write
      acc(1'b1, 16'h1040, 32'd2, 0, r);
      acc(1'b1, 16'h0FFC, 32'hCAFE_F00D, 0, r);
      acc(1'b1, 16'h1040, 32'd1, 0, r);
      acc(1'b0, 16'h0013, 32'd0, 3, r);
      // waitrequest status with busy channel (R7)
      for (int k = 0; k < 4; k++) acc(1'b0, 16'h1070, 32'd0, 0, r);
      // no channel (R2)
      acc(1'b1, 16'h1040, 32'hFFFF_FFFF, 0, r);
      acc(1'b0, 16'h1040, 32'd0, 0, r);
      acc(1'b0, 16'h0100, 32'd0, 4, r);
      acc(1'b0, 16'h1070, 32'd0, 0, r);
      // ignored writes (R10): RO, config and undecoded offsets
      acc(1'b1, 16'h1000, 32'hFFFF_FFFF, 0, r);
      acc(1'b1, 16'h1080, 32'hFFFF_FFFF, 0, r);
      acc(1'b1, 16'h1044, 32'h0, 0, r);
      acc(1'b1, 16'h1056, 32'h0, 0, r);
      acc(1'b1, 16'h1090, 32'h0, 0, r);
      acc(1'b1, 16'h2060, 32'h0, 0, r);
      acc(1'b0, 16'h1004, 32'd0, 0, r);
      acc(1'b0, 16'h10A0, 32'd0, 0, r);
      acc(1'b0, 16'h1040, 32'd0, 0, r);
      acc(1'b0, 16'h1050, 32'd0, 0, r);
      acc(1'b0, 16'h1080, 32'd0, 0, r);
      // reset control (R5)
      acc(1'b1, 16'h1060, 32'd1, 0, r);
      acc(1'b0, 16'h1060, 32'd0, 0, r);
      acc(1'b1, 16'h1060, 32'hFFFF_FFFE, 0, r);

      // random mix
      for (int n = 0; n < 500; n++) begin
         pick = int'($urandom % 10);
         if (pick < 4) a = 16'($urandom % 4096);
         else if (pick < 9) a = 16'(16'h1000 + ($urandom % 9) * 16);
         else a = 16'(16'h1001 + ($urandom % 16'h3000));
         if (a == 16'h1050) acc(1'($urandom), a, {31'd0, 1'(($urandom % 4) != 0)}, 0, r);
         else acc(1'($urandom), a, $urandom, int'($urandom % 4), r);
      end

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule